// File: doc/BRIEF.md
# Modulo Timer PWM Channel

This block is one timer channel that produces a pulse-width modulated output from a 16-bit up-counter. The counter advances on ticks from a power-of-two prescaler. When it reaches a programmable modulo limit, it wraps to zero on the next tick, so the limit sets the period. A channel compare value sets how many counts of each period the output spends high. The output goes high when the counter wraps and goes low when the counter reaches the compare value.

Software programs the block through a small write port. The port sets the modulo limit, the compare value, the prescaler code and the run enable, and it clears the two event flags. The compare value is deliberately unbuffered. A write replaces the value the comparator uses on the very next cycle, even in the middle of a period. A badly timed write can therefore skip a pulse edge, exactly as a program of this kind expects.

Top module: `modtmr_pwm_chan`

## Requirements
- R1: After synchronous reset the output is low, both flags are clear, the counter is 0, the modulo limit is 0xFFFF, the compare value is 0, the prescaler code is 0 and the channel is disabled.
- R2: With modulo limit M and a prescaler that divides by D, the counter counts 0..M and wraps to 0, so the output period is (M+1)*D clock cycles. Each wrap sets the overflow flag.
- R3: The output is driven high on the tick that wraps the counter from M to 0. It is driven low on the tick that brings the counter to the compare value C, so it stays high for C*D cycles of each period. Each match sets the compare flag. With M=255 and C=128 the duty cycle is exactly one half.
- R4: With C=0 the match coincides with the wrap and takes priority over it, so the output stays low (0% duty).
- R5: With C greater than M no match ever occurs. The output stays high for the whole period and the compare flag is never set.
- R6: The prescaler code is field bits [2:0] of the control register (address 2). Code k for k=0..6 divides the clock by 2^k, with code 0 advancing the counter on every clock. Code 7 divides by 64.
- R7: A write to the compare register (address 1) is used by the comparator from the next cycle on. If a new value is written after the counter has passed it but before the counter reaches the old value, that period has no match: the output stays high until the next wrap and the compare flag stays clear.
- R8: The flags are sticky. Writing a 1 to bit 0 (overflow) or bit 1 (compare) at address 3 clears that flag. If an event occurs in the same cycle as its clear, the flag stays set.
- R9: A write to the modulo register (address 0) loads the limit and resets the counter and the prescaler to 0 in the same cycle. The output and the flags keep their values through that write.
- R10: The run enable is control bit 3 (address 2). While it is 0, the counter, the prescaler, the output and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 2 | Register select: 0 modulo, 1 compare, 2 control, 3 flag clear |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | Registered PWM output |
| ovf_flag_o | output | 1 | Sticky overflow (wrap) flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The hardest case to reach from the ports is the dropped compare. The new compare value has to land in the narrow span where the counter has passed it but has not yet reached the old value. The stimulus waits for a rising output edge, which marks counter value 0. It then counts clock cycles at divide-by-1 to a known counter position and writes the smaller value there. The same anchor is used to place a modulo rewrite in the low part of a period and to freeze the counter while the output is high. A cycle-accurate reference model feeds a scoreboard that compares the output and both flags on every cycle.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;

  typedef enum logic [1:0] {
    REG_MOD  = 2'd0,
    REG_CHAN = 2'd1,
    REG_CTRL = 2'd2,
    REG_CLR  = 2'd3
  } reg_sel_e;

  localparam int SEL_W       = 3;
  localparam int CTRL_EN_BIT = 3;
  localparam int CLR_OVF_BIT = 0;
  localparam int CLR_CMP_BIT = 1;

  // prescaler code to log2 of the division ratio, saturating at max_log2
  function automatic int code_to_log2(input logic [SEL_W-1:0] code, input int max_log2);
    int k;
    k = int'(code);
    return (k > max_log2) ? max_log2 : k;
  endfunction

endpackage

// File: rtl/modtmr_regfile.sv
module modtmr_regfile
  import modtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] mod_q,
  output logic [CNT_W-1:0] chan_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             en_q,
  output logic             mod_wr,
  output logic             clr_ovf,
  output logic             clr_cmp
);

  reg_sel_e sel_reg;
  assign sel_reg = reg_sel_e'(wr_addr_i);

  assign mod_wr  = wr_en_i && (sel_reg == REG_MOD);
  assign clr_ovf = wr_en_i && (sel_reg == REG_CLR) && wr_data_i[CLR_OVF_BIT];
  assign clr_cmp = wr_en_i && (sel_reg == REG_CLR) && wr_data_i[CLR_CMP_BIT];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mod_q  <= '1;
      chan_q <= '0;
      sel_q  <= '0;
      en_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (sel_reg)
        REG_MOD:  mod_q  <= wr_data_i;
        REG_CHAN: chan_q <= wr_data_i;
        REG_CTRL: begin
          sel_q <= wr_data_i[SEL_W-1:0];
          en_q  <= wr_data_i[CTRL_EN_BIT];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/modtmr_prescaler.sv
module modtmr_prescaler
  import modtmr_pkg::*;
#(
  parameter int MAX_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int PC_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;
  int              lg;

  always_comb begin
    lg = code_to_log2(sel_i, MAX_LOG2);
    for (int i = 0; i < PC_W; i++) begin
      mask[i] = (i < lg);
    end
  end

  assign tick_o = en_i && ((pc_q & mask) == mask);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      pc_q <= '0;
    end else if (en_i) begin
      pc_q <= pc_q + 1'b1;
    end
  end

endmodule

// File: rtl/modtmr_counter.sv
module modtmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] chan_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_evt_o,
  output logic             match_evt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_top;

  assign at_top  = (cnt_q == mod_i);
  assign cnt_nxt = at_top ? '0 : cnt_q + 1'b1;

  // events are evaluated against the live compare value (no shadow copy)
  assign wrap_evt_o  = tick_i && !restart_i && at_top;
  assign match_evt_o = tick_i && !restart_i && (cnt_nxt == chan_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/modtmr_outstage.sv
module modtmr_outstage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wrap_evt_i,
  input  logic match_evt_i,
  input  logic clr_ovf_i,
  input  logic clr_cmp_i,
  output logic pwm_o,
  output logic ovf_o,
  output logic cmp_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pwm_o <= 1'b0;
      ovf_o <= 1'b0;
      cmp_o <= 1'b0;
    end else begin
      if (match_evt_i) begin
        pwm_o <= 1'b0;
      end else if (wrap_evt_i) begin
        pwm_o <= 1'b1;
      end
      ovf_o <= (ovf_o && !clr_ovf_i) || wrap_evt_i;
      cmp_o <= (cmp_o && !clr_cmp_i) || match_evt_i;
    end
  end

endmodule

// File: rtl/modtmr_pwm_chan.sv
module modtmr_pwm_chan
  import modtmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MAX_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o
);

  logic [CNT_W-1:0] mod_val;
  logic [CNT_W-1:0] chan_val;
  logic [SEL_W-1:0] ps_sel;
  logic             en;
  logic             mod_wr;
  logic             clr_ovf;
  logic             clr_cmp;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             wrap_evt;
  logic             match_evt;

  modtmr_regfile #(.CNT_W(CNT_W)) regs_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mod_q     (mod_val),
    .chan_q    (chan_val),
    .sel_q     (ps_sel),
    .en_q      (en),
    .mod_wr    (mod_wr),
    .clr_ovf   (clr_ovf),
    .clr_cmp   (clr_cmp)
  );

  modtmr_prescaler #(.MAX_LOG2(MAX_LOG2)) pre_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en),
    .restart_i (mod_wr),
    .sel_i     (ps_sel),
    .tick_o    (tick)
  );

  modtmr_counter #(.CNT_W(CNT_W)) ctr_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_i      (tick),
    .restart_i   (mod_wr),
    .mod_i       (mod_val),
    .chan_i      (chan_val),
    .cnt_o       (cnt),
    .wrap_evt_o  (wrap_evt),
    .match_evt_o (match_evt)
  );

  modtmr_outstage out_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wrap_evt_i  (wrap_evt),
    .match_evt_i (match_evt),
    .clr_ovf_i   (clr_ovf),
    .clr_cmp_i   (clr_cmp),
    .pwm_o       (pwm_o),
    .ovf_o       (ovf_flag_o),
    .cmp_o       (cmp_flag_o)
  );

endmodule

// File: rtl/modtmr_pwm_chan_chk.sv
module modtmr_pwm_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             pwm_o,
  input logic             ovf_flag_o,
  input logic             cmp_flag_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_val,
  input logic             en
);

  logic wr_clr_ovf;
  logic wr_clr_cmp;
  assign wr_clr_ovf = wr_en_i && (wr_addr_i == 2'd3) && wr_data_i[0];
  assign wr_clr_cmp = wr_en_i && (wr_addr_i == 2'd3) && wr_data_i[1];

  // R1: first cycle out of reset shows the idle state
  a_r1_reset_state: assert property (@(posedge clk_i)
    $fell(rst_i) |-> (!pwm_o && !ovf_flag_o && !cmp_flag_o && cnt == '0));

  // R2: the counter never runs past the modulo limit
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt <= mod_val);

  // R3: a rising output is always accompanied by a wrap
  a_r3_rise_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pwm_o) |-> ovf_flag_o);

  // R3: a falling output is always accompanied by a match
  a_r3_fall_on_match: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(pwm_o) |-> cmp_flag_o);

  // R8: flags are sticky until a clear write
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_flag_o && !wr_clr_ovf) |=> ovf_flag_o);
  a_r8_cmp_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmp_flag_o && !wr_clr_cmp) |=> cmp_flag_o);

  // R9: a modulo write restarts the counter and leaves the output alone
  a_r9_mod_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == 2'd0) |=> (cnt == '0 && $stable(pwm_o)));

  // R10: disabled channel holds counter and output
  a_r10_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en && !wr_en_i) |=> ($stable(cnt) && $stable(pwm_o)));

endmodule

bind modtmr_pwm_chan modtmr_pwm_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .pwm_o      (pwm_o),
  .ovf_flag_o (ovf_flag_o),
  .cmp_flag_o (cmp_flag_o),
  .cnt        (cnt),
  .mod_val    (mod_val),
  .en         (en)
);

// File: tb/modtmr_pwm_chan_tb_top.sv
module modtmr_pwm_chan_tb_top;
  import modtmr_pkg::*;

  localparam int CNT_W = 16;
  localparam int MAXL  = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             pwm, ovf, cmp;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  modtmr_pwm_chan #(.CNT_W(CNT_W), .MAX_LOG2(MAXL)) dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .pwm_o      (pwm),
    .ovf_flag_o (ovf),
    .cmp_flag_o (cmp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  logic [2:0]       exp_q[$];
  string            tag_q[$];
  logic [CNT_W-1:0] m_mod, m_chan, m_cnt, m_nxt;
  logic [2:0]       m_sel;
  logic             m_en, m_pwm, m_ovf, m_cmp;
  logic [MAXL-1:0]  m_pc, m_mask;
  logic             m_tick, m_mw, m_we, m_ce;

  always @(posedge clk) begin
    if (rst) begin
      m_mod = '1; m_chan = '0; m_cnt = '0; m_sel = '0; m_en = 1'b0;
      m_pwm = 1'b0; m_ovf = 1'b0; m_cmp = 1'b0; m_pc = '0;
    end else begin
      m_mw = wr_en && wr_addr == 2'd0;
      m_mask = MAXL'((1 << ((m_sel > 3'd6) ? 6 : int'(m_sel))) - 1);
      m_tick = m_en && ((m_pc & m_mask) == m_mask);
      m_nxt = (m_cnt == m_mod) ? '0 : m_cnt + 1'b1;
      m_we = m_tick && !m_mw && (m_cnt == m_mod);
      m_ce = m_tick && !m_mw && (m_nxt == m_chan);
      if (m_ce) m_pwm = 1'b0;
      else if (m_we) m_pwm = 1'b1;
      m_ovf = (m_ovf && !(wr_en && wr_addr == 2'd3 && wr_data[0])) || m_we;
      m_cmp = (m_cmp && !(wr_en && wr_addr == 2'd3 && wr_data[1])) || m_ce;
      if (m_mw) begin
        m_pc = '0; m_cnt = '0;
      end else begin
        if (m_en) m_pc = m_pc + 1'b1;
        if (m_tick) m_cnt = m_nxt;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_mod = wr_data;
          2'd1: m_chan = wr_data;
          2'd2: begin m_sel = wr_data[2:0]; m_en = wr_data[3]; end
          default: ;
        endcase
      end
    end
    exp_q.push_back({m_pwm, m_ovf, m_cmp});
    tag_q.push_back(cur_tag);
  end

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({pwm, ovf, cmp} == e, {t, " scoreboard pwm/ovf/cmp"}, int'({pwm, ovf, cmp}), int'(e));
    end
  end

  // ---------------- driver helpers ----------------
  task automatic wr(input reg_sel_e a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(output int n);
    logic prev;
    n = 0;
    prev = pwm;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if (pwm && !prev) break;
      prev = pwm;
    end
  endtask

  task automatic count_high(input int cyc, output int h);
    h = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pwm) h++;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int n, h;
    logic held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm == 1'b0, "R1 pwm after reset", int'(pwm), 0);
    check(!ovf && !cmp, "R1 flags after reset", int'({ovf, cmp}), 0);

    // R2/R3: 50 percent duty at divide-by-1
    cur_tag = "R2/R3";
    wr(REG_MOD, 255); wr(REG_CHAN, 128); wr(REG_CTRL, 8);
    wait_rise(n); wait_rise(n);
    check(n == 256, "R2 period cycles", n, 256);
    count_high(256, h);
    check(h == 128, "R3 high cycles", h, 128);

    // R4: zero compare value
    cur_tag = "R4";
    wr(REG_CHAN, 0);
    repeat (300) @(negedge clk);
    count_high(256, h);
    check(h == 0, "R4 high cycles", h, 0);

    // R5: compare above modulo
    cur_tag = "R5";
    wr(REG_CHAN, 300);
    repeat (300) @(negedge clk);
    wr(REG_CLR, 3);
    count_high(256, h);
    check(h == 256, "R5 high cycles", h, 256);
    check(cmp == 1'b0, "R5 compare flag", int'(cmp), 0);
    check(ovf == 1'b1, "R5 overflow flag", int'(ovf), 1);

    // R6: prescaler divisions
    cur_tag = "R6";
    wr(REG_MOD, 9); wr(REG_CHAN, 3); wr(REG_CTRL, 8 | 2);
    wait_rise(n); wait_rise(n);
    check(n == 40, "R6 div4 period", n, 40);
    count_high(40, h);
    check(h == 12, "R6 div4 high", h, 12);
    wr(REG_MOD, 1); wr(REG_CHAN, 1); wr(REG_CTRL, 8 | 5);
    wait_rise(n); wait_rise(n);
    check(n == 64, "R6 div32 period", n, 64);
    wr(REG_MOD, 3); wr(REG_CTRL, 8 | 7);
    wait_rise(n); wait_rise(n);
    check(n == 256, "R6 code7 period", n, 256);
    count_high(256, h);
    check(h == 64, "R6 code7 high", h, 64);

    // R7: dropped compare after an unbuffered write
    cur_tag = "R7";
    wr(REG_MOD, 99); wr(REG_CHAN, 60); wr(REG_CTRL, 8);
    wait_rise(n);
    repeat (30) @(negedge clk);
    wr(REG_CLR, 2);
    wr(REG_CHAN, 20);
    repeat (40) @(negedge clk);
    check(pwm == 1'b1, "R7 output still high past old compare", int'(pwm), 1);
    check(cmp == 1'b0, "R7 no compare in skipped period", int'(cmp), 0);
    wait_rise(n);
    count_high(100, h);
    check(h == 20, "R7 new width next period", h, 20);

    // R8: sticky flags, clear, and set-wins
    cur_tag = "R8";
    wr(REG_CTRL, 0);
    wr(REG_CLR, 3);
    check(!ovf && !cmp, "R8 flags cleared", int'({ovf, cmp}), 0);
    wr(REG_MOD, 0); wr(REG_CHAN, 5); wr(REG_CTRL, 8);
    repeat (5) @(negedge clk);
    wr(REG_CLR, 1);
    check(ovf == 1'b1, "R8 set wins over clear", int'(ovf), 1);
    wr(REG_CTRL, 0);
    wr(REG_CLR, 1);
    check(ovf == 1'b0, "R8 overflow cleared", int'(ovf), 0);

    // R9: modulo write restarts the period
    cur_tag = "R9";
    wr(REG_MOD, 99); wr(REG_CHAN, 50); wr(REG_CTRL, 8);
    wait_rise(n);
    repeat (70) @(negedge clk);
    wr(REG_MOD, 199);
    check(pwm == 1'b0, "R9 output kept on modulo write", int'(pwm), 0);
    wait_rise(n);
    check(n == 200, "R9 cycles to first wrap after restart", n, 200);

    // R10: disable freezes everything
    cur_tag = "R10";
    wait_rise(n);
    repeat (10) @(negedge clk);
    wr(REG_CTRL, 0);
    held = pwm;
    repeat (100) @(negedge clk);
    check(pwm == held && pwm == 1'b1, "R10 output frozen", int'(pwm), 1);
    wr(REG_CTRL, 8);
    repeat (300) @(negedge clk);

    finish_run();
  end

endmodule